// File: doc/BRIEF.md
# DDR Write Data Burst Scheduler

This block sits on the controller side of a double-data-rate memory interface. It turns each accepted write command into a data burst placed on the data path at the right clock. The command strobe arrives first. The data burst follows a programmable write latency, computed as the additive latency plus the CAS latency minus one. The block carries pending bursts in a marker delay line, so several writes can be in flight at once. When the first data clock of a burst comes round, it pulls one rising-edge/falling-edge word pair per clock from a first-word-fall-through write FIFO. It also raises the data output enable and frames the clocks around the burst with a strobe preamble and postamble.

Writes issued exactly half a burst length apart form one continuous data stream, with no idle strobe clock between them. A sequencer with five named states drives the output framing:
- `ST_IDLE`: nothing driven.
- `ST_PRE`: strobe preamble, both halves of the clock.
- `ST_BURST`: data clock.
- `ST_POST`: postamble, first half of the clock only.
- `ST_TURN`: one clock that is both postamble and preamble, between bursts one clock apart.

The transitions are:
- `ST_IDLE`→`ST_PRE` when a burst starts in two clocks.
- `ST_PRE`→`ST_BURST`.
- `ST_BURST`→`ST_BURST` while beats remain, or when the next burst chains on.
- `ST_BURST`→`ST_TURN` when the next burst starts after a one-clock gap.
- `ST_BURST`→`ST_POST` otherwise.
- `ST_POST`→`ST_PRE` when a burst starts in two clocks, else `ST_IDLE`.
- `ST_TURN`→`ST_BURST`.

Top module: `ddr_wr_sched`

## Requirements
- R1: The first data clock (dq_oe high) of a burst is the clock WL = cfg_al + cfg_cl − 1 clocks after the clock in which wr_cmd is high. WL must lie between 2 and MAX_WL.
- R2: cfg_bl8 = 0 selects burst length 4, which is 2 data clocks. cfg_bl8 = 1 selects burst length 8, which is 4 data clocks. On each data clock dq_rise carries the even beat and dq_fall the odd beat, taken from the FIFO head in order.
- R3: Writes spaced exactly BL/2 clocks apart produce one unbroken run of dq_oe and of both strobe enables.
- R4: In the clock just before a burst's first data clock, dqs_oe_rise and dqs_oe_fall are both high and dq_oe is low. The preamble never coincides with a data clock of an earlier burst.
- R5: In the clock after the last data clock, when no burst follows within two clocks, dqs_oe_rise is 1 and dqs_oe_fall is 0. This is the half-clock postamble.
- R6: When the next burst begins after exactly one idle clock, that clock has dq_oe low and both strobe enables high.
- R7: fifo_pop is high exactly on data clocks where fifo_empty is low, and never on any other clock.
- R8: A data clock with fifo_empty high drives zeros on dq_rise and dq_fall and does not pop. underflow_err rises on the next clock and stays high until reset.
- R9: On every clock that is not a data clock, dq_rise and dq_fall are zero and fifo_pop is low.
- R10: While rst_n is low, all outputs are zero.
- R11: Up to MAX_WL/(BL/2) writes can be in flight. Four writes spaced BL/2 apart produce exactly 4·BL/2 data clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | CFGW | Additive latency in clocks |
| cfg_cl | input | CFGW | CAS latency in clocks |
| cfg_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| wr_cmd | input | 1 | One-clock strobe per accepted write |
| fifo_empty | input | 1 | Write FIFO has no word pair |
| fifo_rise | input | DW | FIFO head, rising-edge word |
| fifo_fall | input | DW | FIFO head, falling-edge word |
| fifo_pop | output | 1 | Consume the FIFO head this clock |
| dq_rise | output | DW | Data for the rising half of the clock |
| dq_fall | output | DW | Data for the falling half of the clock |
| dq_oe | output | 1 | Data output enable |
| dqs_oe_rise | output | 1 | Strobe enable, first half of the clock |
| dqs_oe_fall | output | 1 | Strobe enable, second half of the clock |
| underflow_err | output | 1 | Sticky FIFO underflow flag |

## Verification
The assertions check several rules on every cycle:
- strobe framing around each dq_oe run, with a preamble before it and a half postamble after;
- pops only on data clocks with a non-empty FIFO;
- the stickiness of the underflow flag and its link to empty data clocks;
- zero data outside data clocks;
- data runs that are whole multiples of BL/2.

Other behaviours show only in the bench's sweeps over additive latency, CAS latency and burst length. These are the exact latency of the first data clock, the order of words on the rising and falling halves, and the merging of back-to-back bursts into a single run. The bench also covers the shared post/preamble clock between bursts one clock apart and the count of bursts that can be in flight at once.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_BURST = 3'd2,
        ST_POST  = 3'd3,
        ST_TURN  = 3'd4
    } wbs_state_e;
endpackage

// File: rtl/wbs_latency_line.sv
`timescale 1ns/1ps
// Marker delay line: a write enters at depth wl-1 and walks toward index 0.
module wbs_latency_line #(
    parameter int MAX_WL = 16,
    localparam int WLW = $clog2(MAX_WL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_cmd,
    input  logic [WLW-1:0] wl,
    output logic           start_next,  // next clock is a first data clock
    output logic           start_soon   // the clock after next is a first data clock
);
    logic [MAX_WL-1:0] mark_q;
    logic [MAX_WL-1:0] mark_d;

    for (genvar i = 0; i < MAX_WL; i++) begin : g_stage
        if (i < MAX_WL - 1) begin : g_mid
            assign mark_d[i] = mark_q[i+1] | (wr_cmd && (wl == WLW'(i + 1)));
        end else begin : g_top
            assign mark_d[i] = wr_cmd && (wl == WLW'(i + 1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mark_q <= '0;
        else        mark_q <= mark_d;
    end

    assign start_next = mark_d[0];
    assign start_soon = mark_d[1];
endmodule

// File: rtl/wbs_burst_fsm.sv
`timescale 1ns/1ps
module wbs_burst_fsm
    import wbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bl8,
    input  logic start_next,
    input  logic start_soon,
    output logic data_clk,
    output logic strobe_rise,
    output logic strobe_fall
);
    localparam int CW = 2;

    wbs_state_e    state_q, state_d;
    logic [CW-1:0] left_q;
    logic          last_beat;
    logic          load_cnt;

    assign last_beat = (left_q == '0);
    assign load_cnt  = (state_d == ST_BURST) && ((state_q != ST_BURST) || last_beat);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start_soon ? ST_PRE : ST_IDLE;
            ST_PRE:   state_d = start_next ? ST_BURST : ST_IDLE;
            ST_BURST: begin
                if (!last_beat)      state_d = ST_BURST;
                else if (start_next) state_d = ST_BURST;
                else if (start_soon) state_d = ST_TURN;
                else                 state_d = ST_POST;
            end
            ST_POST:  state_d = start_soon ? ST_PRE : ST_IDLE;
            ST_TURN:  state_d = ST_BURST;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load_cnt)                 left_q <= bl8 ? CW'(3) : CW'(1);
            else if (state_q == ST_BURST) left_q <= left_q - CW'(1);
        end
    end

    always_comb begin
        data_clk    = 1'b0;
        strobe_rise = 1'b0;
        strobe_fall = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PRE:   begin strobe_rise = 1'b1; strobe_fall = 1'b1; end
            ST_BURST: begin data_clk = 1'b1; strobe_rise = 1'b1; strobe_fall = 1'b1; end
            ST_POST:  strobe_rise = 1'b1;
            ST_TURN:  begin strobe_rise = 1'b1; strobe_fall = 1'b1; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/wbs_data_path.sv
`timescale 1ns/1ps
module wbs_data_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_clk,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_rise,
    input  logic [DW-1:0] fifo_fall,
    output logic          fifo_pop,
    output logic [DW-1:0] dq_rise,
    output logic [DW-1:0] dq_fall,
    output logic          underflow_err
);
    logic take;

    assign take     = data_clk && !fifo_empty;
    assign fifo_pop = take;
    assign dq_rise  = take ? fifo_rise : '0;
    assign dq_fall  = take ? fifo_fall : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)                       underflow_err <= 1'b0;
        else if (data_clk && fifo_empty)  underflow_err <= 1'b1;
    end
endmodule

// File: rtl/ddr_wr_sched.sv
`timescale 1ns/1ps
module ddr_wr_sched #(
    parameter int DW     = 8,
    parameter int MAX_WL = 16,
    parameter int CFGW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CFGW-1:0] cfg_al,
    input  logic [CFGW-1:0] cfg_cl,
    input  logic            cfg_bl8,
    input  logic            wr_cmd,
    input  logic            fifo_empty,
    input  logic [DW-1:0]   fifo_rise,
    input  logic [DW-1:0]   fifo_fall,
    output logic            fifo_pop,
    output logic [DW-1:0]   dq_rise,
    output logic [DW-1:0]   dq_fall,
    output logic            dq_oe,
    output logic            dqs_oe_rise,
    output logic            dqs_oe_fall,
    output logic            underflow_err
);
    localparam int WLW = $clog2(MAX_WL + 1);

    logic [WLW-1:0] wl;
    logic           start_next;
    logic           start_soon;

    assign wl = WLW'(cfg_al) + WLW'(cfg_cl) - WLW'(1);

    wbs_latency_line #(.MAX_WL(MAX_WL)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (wr_cmd),
        .wl         (wl),
        .start_next (start_next),
        .start_soon (start_soon)
    );

    wbs_burst_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bl8         (cfg_bl8),
        .start_next  (start_next),
        .start_soon  (start_soon),
        .data_clk    (dq_oe),
        .strobe_rise (dqs_oe_rise),
        .strobe_fall (dqs_oe_fall)
    );

    wbs_data_path #(.DW(DW)) u_data (
        .clk           (clk),
        .rst_n         (rst_n),
        .data_clk      (dq_oe),
        .fifo_empty    (fifo_empty),
        .fifo_rise     (fifo_rise),
        .fifo_fall     (fifo_fall),
        .fifo_pop      (fifo_pop),
        .dq_rise       (dq_rise),
        .dq_fall       (dq_fall),
        .underflow_err (underflow_err)
    );
endmodule

// File: rtl/ddr_wr_sched_chk.sv
`timescale 1ns/1ps
module ddr_wr_sched_chk #(
    parameter int DW     = 8,
    parameter int MAX_WL = 16,
    parameter int CFGW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CFGW-1:0] cfg_al,
    input logic [CFGW-1:0] cfg_cl,
    input logic            cfg_bl8,
    input logic            fifo_empty,
    input logic            fifo_pop,
    input logic [DW-1:0]   dq_rise,
    input logic [DW-1:0]   dq_fall,
    input logic            dq_oe,
    input logic            dqs_oe_rise,
    input logic            dqs_oe_fall,
    input logic            underflow_err
);
    logic [7:0] run_q;
    int         lat_sum;

    assign lat_sum = int'(cfg_al) + int'(cfg_cl) - 1;

    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= '0;
        else if (dq_oe) run_q <= run_q + 8'd1;
        else            run_q <= '0;
    end

    a_r1_wl_range: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_sum >= 2) && (lat_sum <= MAX_WL));

    a_r2_whole_bursts: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> (cfg_bl8 ? (run_q[1:0] == 2'd0) : (run_q[0] == 1'b0)));

    a_r4_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> ($past(dqs_oe_rise) && $past(dqs_oe_fall)));

    a_r4_oe_framed: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dqs_oe_rise && dqs_oe_fall));

    a_r5_postamble: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> dqs_oe_rise);

    a_r7_pop_only_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (dq_oe && !fifo_empty));

    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && fifo_empty) |=> underflow_err);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);

    a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> ((dq_rise == '0) && (dq_fall == '0)));
endmodule

bind ddr_wr_sched ddr_wr_sched_chk #(.DW(DW), .MAX_WL(MAX_WL), .CFGW(CFGW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_al        (cfg_al),
    .cfg_cl        (cfg_cl),
    .cfg_bl8       (cfg_bl8),
    .fifo_empty    (fifo_empty),
    .fifo_pop      (fifo_pop),
    .dq_rise       (dq_rise),
    .dq_fall       (dq_fall),
    .dq_oe         (dq_oe),
    .dqs_oe_rise   (dqs_oe_rise),
    .dqs_oe_fall   (dqs_oe_fall),
    .underflow_err (underflow_err)
);

// File: tb/ddr_wr_sched_tb.sv
`timescale 1ns/1ps
module ddr_wr_sched_tb;
    localparam int DW     = 8;
    localparam int MAX_WL = 16;
    localparam int CFGW   = 4;
    localparam int NT     = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CFGW-1:0] cfg_al = '0;
    logic [CFGW-1:0] cfg_cl = 4'd3;
    logic            cfg_bl8 = 1'b0;
    logic            wr_cmd = 1'b0;
    logic            fifo_empty;
    logic [DW-1:0]   fifo_rise, fifo_fall;
    logic            fifo_pop;
    logic [DW-1:0]   dq_rise, dq_fall;
    logic            dq_oe, dqs_oe_rise, dqs_oe_fall, underflow_err;

    int head = 0;
    int avail = 0;
    int n_chk = 0;
    int n_err = 0;

    assign fifo_empty = (head >= avail);
    assign fifo_rise  = DW'(2 * head + 1);
    assign fifo_fall  = DW'(2 * head + 2);

    always #2 clk = ~clk;

    ddr_wr_sched #(.DW(DW), .MAX_WL(MAX_WL), .CFGW(CFGW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
        .wr_cmd(wr_cmd), .fifo_empty(fifo_empty), .fifo_rise(fifo_rise), .fifo_fall(fifo_fall),
        .fifo_pop(fifo_pop), .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
        .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall), .underflow_err(underflow_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic bit is_data(int t, int wl, int half, int nc, int sp);
        for (int k = 0; k < nc; k++) begin
            if (t >= k * sp + wl && t < k * sp + wl + half) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic run_scn(input int al, input int cl, input int bl8,
                           input int nc, input int sp, input int av);
        bit oe_a[NT];
        bit rs_a[NT];
        bit fl_a[NT];
        int wl, half, nd, runs, total;
        bit err_exp, under, popped, d, ex_rs, ex_fl;
        int er, ef;

        @(negedge clk);
        rst_n   = 1'b0;
        wr_cmd  = 1'b0;
        cfg_al  = CFGW'(al);
        cfg_cl  = CFGW'(cl);
        cfg_bl8 = bl8[0];
        head    = 0;
        avail   = av;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R10: quiet outputs while held in reset
        chk(!dq_oe && !dqs_oe_rise && !dqs_oe_fall && !fifo_pop && !underflow_err
            && dq_rise == '0 && dq_fall == '0, "R10",
            int'({dq_oe, dqs_oe_rise, dqs_oe_fall, fifo_pop, underflow_err}), 0);
        rst_n = 1'b1;

        wl = al + cl - 1;
        half = bl8 ? 4 : 2;
        nd = 0;
        err_exp = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (t > 0) @(negedge clk);
            wr_cmd = ((t % sp) == 0) && ((t / sp) < nc);
            #1;
            d     = is_data(t, wl, half, nc, sp);
            ex_fl = d || is_data(t + 1, wl, half, nc, sp);
            ex_rs = ex_fl || is_data(t - 1, wl, half, nc, sp);
            under = 1'b0;
            chk(dq_oe == d, "R1", int'(dq_oe), int'(d));
            chk(dqs_oe_fall == ex_fl, "R4", int'(dqs_oe_fall), int'(ex_fl));
            chk(dqs_oe_rise == ex_rs, "R5", int'(dqs_oe_rise), int'(ex_rs));
            chk(underflow_err == err_exp, "R8", int'(underflow_err), int'(err_exp));
            if (d) begin
                under = (nd >= av);
                er = under ? 0 : ((2 * nd + 1) & 8'hff);
                ef = under ? 0 : ((2 * nd + 2) & 8'hff);
                chk(int'(dq_rise) == er && int'(dq_fall) == ef, under ? "R8" : "R2",
                    int'({dq_rise, dq_fall}), (er << 8) | ef);
                chk(fifo_pop == !under, "R7", int'(fifo_pop), int'(!under));
                nd++;
            end else begin
                chk(dq_rise == '0 && dq_fall == '0 && !fifo_pop, "R9",
                    int'({fifo_pop, dq_rise, dq_fall}), 0);
            end
            oe_a[t] = dq_oe;
            rs_a[t] = dqs_oe_rise;
            fl_a[t] = dqs_oe_fall;
            popped  = fifo_pop;
            @(posedge clk);
            #1;
            if (popped) head++;
            if (under) err_exp = 1'b1;
        end
        wr_cmd = 1'b0;

        runs = 0;
        total = 0;
        for (int t = 0; t < NT; t++) begin
            if (oe_a[t]) total++;
            if (oe_a[t] && (t == 0 || !oe_a[t-1])) runs++;
        end
        if (sp == half) begin
            chk(runs == 1, "R3", runs, 1);
            chk(total == nc * half, "R11", total, nc * half);
        end
        if (sp == half + 1) begin
            chk(!oe_a[wl + half] && rs_a[wl + half] && fl_a[wl + half], "R6",
                int'({oe_a[wl + half], rs_a[wl + half], fl_a[wl + half]}), 3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int bl = 0; bl < 2; bl++) begin
            for (int al = 0; al < 4; al++) begin
                for (int cl = 3; cl < 7; cl++) begin
                    int hf;
                    hf = bl ? 4 : 2;
                    run_scn(al, cl, bl, 1, 1, 16);       // single burst
                    run_scn(al, cl, bl, 4, hf, 64);      // chained, R3 / R11
                    run_scn(al, cl, bl, 2, hf + 1, 64);  // one idle clock, R6
                    run_scn(al, cl, bl, 2, hf + 2, 64);  // two idle clocks
                    run_scn(al, cl, bl, 1, 1, 1);        // underflow, R8
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule